// File: doc/BRIEF.md
# Cache Burst-Ready Decision Logic

This block produces the active-low burst-ready indication that a processor receives during a secondary-cache access. It takes the outcome of an external tag comparison (hit), the valid and write-through flags stored for the addressed line, the processor's cycle direction, the tag and status bus activity strobes, an external ready source, a force-not-ready input, a status-interpretation mode and a ready-output disable. From these it picks one outcome by a fixed priority and registers that outcome on the rising clock edge.

The tag store and comparator are not part of the block; their results arrive as plain inputs. A disabled output, which would be high impedance on a board, is modelled here by a separate output-valid flag that drops low while the ready level is parked high.

The priority, from strongest to weakest, is: output disable, external ready, tag or status bus activity, force-not-ready, invalid line, write-through write, and finally the hit comparison. The valid and write-through rules apply only in dedicated-status mode.

Top module: `brdy_decide`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge leaves `rdy_n` = 1 and `rdy_valid` = 0 after that edge.
- R2: When `rdy_disable` = 1 at a rising edge, after that edge `rdy_valid` = 0 and `rdy_n` = 1, whatever every other input is.
- R3: When the output is not disabled and `ext_rdy_n` = 0 at a rising edge, after that edge `rdy_n` = 0 and `rdy_valid` = 1, overriding every rule below it.
- R4: `ext_rdy_n` is sampled only at the rising edge: a low pulse that starts and ends between two edges leaves `rdy_n` unchanged.
- R5: Without disable or external ready, if any of `tag_read`, `tag_write` or `stat_write` is 1 at the edge, `rdy_n` = 1 after it.
- R6: Without any of the rules above applying, `force_busy` = 1 at the edge gives `rdy_n` = 1 after it, even on a hit.
- R7: In dedicated-status mode (`generic_mode` = 0), with no rule above applying, `line_valid` = 0 gives `rdy_n` = 1.
- R8: In dedicated-status mode, with no rule above applying, `cyc_write` = 1 together with `line_wt` = 1 gives `rdy_n` = 1.
- R9: When no rule above applies, `rdy_n` after the edge equals the inverse of `hit` at the edge, and `rdy_valid` = 1.
- R10: In generic-status mode (`generic_mode` = 1), `line_valid` and `line_wt` have no effect on `rdy_n`.
- R11: For all 2048 combinations of the eleven decision inputs, the registered result matches the priority order R2, R3, R5, R6, R7, R8, R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| rdy_disable | input | 1 | 1 disables the ready output |
| ext_rdy_n | input | 1 | External ready, active low, sampled at the edge |
| tag_read | input | 1 | Tag bus is being read |
| tag_write | input | 1 | Tag bus is being written |
| stat_write | input | 1 | Status bits are being written |
| force_busy | input | 1 | 1 holds ready inactive |
| generic_mode | input | 1 | 1 = status bits are user-defined, 0 = dedicated |
| cyc_write | input | 1 | 1 = processor write cycle, 0 = read |
| hit | input | 1 | Tag comparison result, 1 = equal |
| line_valid | input | 1 | Stored valid flag of the addressed line |
| line_wt | input | 1 | Stored write-through flag of the addressed line |
| rdy_n | output | 1 | Registered burst ready, active low |
| rdy_valid | output | 1 | 1 when `rdy_n` is driven, 0 when disabled |

## Verification
The assertions take every decision input to be a known level at each rising edge, since the outcome is a pure function of those levels and any unknown bit would spread to `rdy_n`. The stimulus honours this by setting every input before reset is released and changing inputs only on the falling edge, with the one deliberate exception of the mid-cycle pulse on `ext_rdy_n`, which is raised and dropped well clear of both edges. Results are sampled one time unit after the rising edge, once the register has updated.

// File: rtl/brdy_pkg.sv
package brdy_pkg;

    // Which rule decided the ready outcome, strongest first.
    typedef enum logic [2:0] {
        SRC_OFF     = 3'd0,
        SRC_EXT     = 3'd1,
        SRC_BUS     = 3'd2,
        SRC_FORCE   = 3'd3,
        SRC_INVALID = 3'd4,
        SRC_WTHRU   = 3'd5,
        SRC_CMP     = 3'd6
    } brdy_src_e;

    // Conditions that each hold ready inactive.
    typedef struct packed {
        logic bus;
        logic force_hold;
        logic invalid;
        logic wthru;
    } brdy_hold_t;

    // Registered outcome.
    typedef struct packed {
        logic rdy_n;
        logic valid;
    } brdy_out_t;

endpackage

// File: rtl/brdy_hold_screen.sv
module brdy_hold_screen
    import brdy_pkg::*;
(
    input  logic       tag_read,
    input  logic       tag_write,
    input  logic       stat_write,
    input  logic       force_busy,
    input  logic       generic_mode,
    input  logic       cyc_write,
    input  logic       line_valid,
    input  logic       line_wt,
    output brdy_hold_t holds
);

    logic dedicated;

    always_comb begin
        dedicated        = ~generic_mode;
        holds.bus        = tag_read | tag_write | stat_write;
        holds.force_hold = force_busy;
        // Status flags only count when their meaning is fixed.
        holds.invalid    = dedicated & ~line_valid;
        holds.wthru      = dedicated & cyc_write & line_wt;
    end

    // A user-defined status mode must never raise a line-flag hold.
    always_comb begin
        if (generic_mode === 1'b1) begin
            assert_generic_ignores_flags_R10: assert (!holds.invalid && !holds.wthru);
        end
    end

endmodule

// File: rtl/brdy_arbiter.sv
module brdy_arbiter
    import brdy_pkg::*;
(
    input  logic       rdy_disable,
    input  logic       ext_rdy_n,
    input  brdy_hold_t holds,
    input  logic       hit,
    output brdy_out_t  out_d
);

    brdy_src_e src;

    // Fixed priority pick.
    always_comb begin
        if (rdy_disable)           src = SRC_OFF;
        else if (!ext_rdy_n)       src = SRC_EXT;
        else if (holds.bus)        src = SRC_BUS;
        else if (holds.force_hold) src = SRC_FORCE;
        else if (holds.invalid)    src = SRC_INVALID;
        else if (holds.wthru)      src = SRC_WTHRU;
        else                       src = SRC_CMP;
    end

    always_comb begin
        out_d.valid = 1'b1;
        out_d.rdy_n = 1'b1;
        case (src)
            SRC_OFF: begin
                out_d.valid = 1'b0;
                out_d.rdy_n = 1'b1;
            end
            SRC_EXT: out_d.rdy_n = 1'b0;
            SRC_CMP: out_d.rdy_n = ~hit;
            default: out_d.rdy_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/brdy_decide.sv
module brdy_decide
    import brdy_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rdy_disable,
    input  logic ext_rdy_n,
    input  logic tag_read,
    input  logic tag_write,
    input  logic stat_write,
    input  logic force_busy,
    input  logic generic_mode,
    input  logic cyc_write,
    input  logic hit,
    input  logic line_valid,
    input  logic line_wt,
    output logic rdy_n,
    output logic rdy_valid
);

    localparam brdy_out_t OUT_RESET = '{rdy_n: 1'b1, valid: 1'b0};

    brdy_hold_t holds;
    brdy_out_t  dec;
    brdy_out_t  out_d;
    brdy_out_t  out_q;

    brdy_hold_screen u_screen (
        .tag_read     (tag_read),
        .tag_write    (tag_write),
        .stat_write   (stat_write),
        .force_busy   (force_busy),
        .generic_mode (generic_mode),
        .cyc_write    (cyc_write),
        .line_valid   (line_valid),
        .line_wt      (line_wt),
        .holds        (holds)
    );

    brdy_arbiter u_arb (
        .rdy_disable (rdy_disable),
        .ext_rdy_n   (ext_rdy_n),
        .holds       (holds),
        .hit         (hit),
        .out_d       (dec)
    );

    always_comb begin
        out_d = dec;
        if (rst) out_d = OUT_RESET;
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign rdy_n     = out_q.rdy_n;
    assign rdy_valid = out_q.valid;

    // Assertions on the registered result against inputs at the prior edge.
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (rdy_n && !rdy_valid));

    assert_disable_R2: assert property (@(posedge clk) disable iff (rst)
        rdy_disable |=> (rdy_n && !rdy_valid));

    assert_ext_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (!rdy_disable && !ext_rdy_n) |=> (!rdy_n && rdy_valid));

    assert_bus_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!rdy_disable && ext_rdy_n && (tag_read || tag_write || stat_write))
        |=> (rdy_n && rdy_valid));

    assert_force_R6: assert property (@(posedge clk) disable iff (rst)
        (!rdy_disable && ext_rdy_n && force_busy) |=> rdy_n);

    assert_invalid_R7: assert property (@(posedge clk) disable iff (rst)
        (!rdy_disable && ext_rdy_n && !generic_mode && !line_valid) |=> rdy_n);

    assert_wthru_R8: assert property (@(posedge clk) disable iff (rst)
        (!rdy_disable && ext_rdy_n && !generic_mode && cyc_write && line_wt)
        |=> rdy_n);

    assert_compare_R9: assert property (@(posedge clk) disable iff (rst)
        (!rdy_disable && ext_rdy_n && !tag_read && !tag_write && !stat_write
         && !force_busy && (generic_mode || (line_valid && !(cyc_write && line_wt))))
        |=> (rdy_valid && (rdy_n == !$past(hit))));

endmodule

// File: tb/brdy_decide_tb.sv
module brdy_decide_tb_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rdy_disable = 1'b0, ext_rdy_n = 1'b1, tag_read = 1'b0, tag_write = 1'b0;
    logic stat_write = 1'b0, force_busy = 1'b0, generic_mode = 1'b0, cyc_write = 1'b0;
    logic hit = 1'b0, line_valid = 1'b1, line_wt = 1'b0;
    logic rdy_n, rdy_valid;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brdy_decide dut_i (
        .clk(clk), .rst(rst), .rdy_disable(rdy_disable), .ext_rdy_n(ext_rdy_n),
        .tag_read(tag_read), .tag_write(tag_write), .stat_write(stat_write),
        .force_busy(force_busy), .generic_mode(generic_mode), .cyc_write(cyc_write),
        .hit(hit), .line_valid(line_valid), .line_wt(line_wt),
        .rdy_n(rdy_n), .rdy_valid(rdy_valid)
    );

    // Bit order of a vector: {dis, ext_n, trd, twr, swr, frc, gen, wr, hit, vld, wt}
    function automatic logic [1:0] model(input logic [10:0] v);
        logic dis, extn, trd, twr, swr, frc, gen, wr, h, vld, wt;
        {dis, extn, trd, twr, swr, frc, gen, wr, h, vld, wt} = v;
        if (dis)               return 2'b10;   // {rdy_n, valid}
        if (!extn)             return 2'b01;
        if (trd | twr | swr)   return 2'b11;
        if (frc)               return 2'b11;
        if (!gen && !vld)      return 2'b11;
        if (!gen && wr && wt)  return 2'b11;
        return {~h, 1'b1};
    endfunction

    task automatic drive(input logic [10:0] v);
        {rdy_disable, ext_rdy_n, tag_read, tag_write, stat_write, force_busy,
         generic_mode, cyc_write, hit, line_valid, line_wt} = v;
    endtask

    task automatic check(input string req, input logic exp_n, input logic exp_v);
        checks++;
        if (rdy_n !== exp_n || rdy_valid !== exp_v) begin
            failures++;
            $display("FAIL %s: rdy_n=%b rdy_valid=%b expected rdy_n=%b rdy_valid=%b",
                     req, rdy_n, rdy_valid, exp_n, exp_v);
        end
    endtask

    // Drive on falling edge, let a rising edge pass, sample 1 unit later.
    task automatic step(input logic [10:0] v);
        @(negedge clk);
        drive(v);
        @(posedge clk);
        #1;
    endtask

    task automatic apply_check(input string req, input logic [10:0] v);
        logic [1:0] e;
        e = model(v);
        step(v);
        check(req, e[1], e[0]);
    endtask

    // Baseline: enabled, ext idle, no bus, dedicated, read, valid line, no wt.
    localparam logic [10:0] BASE = 11'b0_1_000_0_0_0_0_1_0;

    task automatic t_reset();
        @(negedge clk); drive(BASE | 11'b00000000100); rst = 1'b1;
        @(posedge clk); #1;
        check("R1", 1'b1, 1'b0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_disable();
        step(BASE | 11'b00000000100);
        check("R9", 1'b0, 1'b1);
        step(11'b1_0_000_0_0_0_1_1_0);
        check("R2", 1'b1, 1'b0);
    endtask

    task automatic t_ext();
        step(11'b0_0_111_1_0_1_0_0_1);
        check("R3", 1'b0, 1'b1);
    endtask

    task automatic t_ext_sync();
        step(BASE);
        check("R9", 1'b1, 1'b1);
        @(negedge clk); #1 ext_rdy_n = 1'b0; #2 ext_rdy_n = 1'b1;
        @(posedge clk); #1;
        check("R4", 1'b1, 1'b1);
        step(BASE & ~11'b01000000000);
        check("R3", 1'b0, 1'b1);
        @(negedge clk); drive(BASE); #1 ext_rdy_n = 1'b0; #2 ext_rdy_n = 1'b1;
        #1 check("R4", 1'b0, 1'b1);
        @(posedge clk); #1;
        check("R4", 1'b1, 1'b1);
    endtask

    task automatic t_bus();
        step(BASE | 11'b00100000100); check("R5", 1'b1, 1'b1);
        step(BASE | 11'b00010000100); check("R5", 1'b1, 1'b1);
        step(BASE | 11'b00001000100); check("R5", 1'b1, 1'b1);
    endtask

    task automatic t_force();
        step(BASE | 11'b00000100100); check("R6", 1'b1, 1'b1);
        step(BASE | 11'b00000110100); check("R6", 1'b1, 1'b1);
    endtask

    task automatic t_invalid();
        step((BASE | 11'b00000000100) & ~11'b00000000010); check("R7", 1'b1, 1'b1);
    endtask

    task automatic t_wthru();
        step(BASE | 11'b00000001101); check("R8", 1'b1, 1'b1);
        step(BASE | 11'b00000000101); check("R9", 1'b0, 1'b1);
    endtask

    task automatic t_generic();
        step(11'b0_1_000_0_1_1_1_0_1); check("R10", 1'b0, 1'b1);
        step(11'b0_1_000_0_1_0_0_0_0); check("R10", 1'b1, 1'b1);
    endtask

    task automatic t_table();
        for (int i = 0; i < 2048; i++) begin
            apply_check("R11", i[10:0]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        drive(BASE);
        repeat (2) @(posedge clk);
        t_reset();
        t_disable();
        t_ext();
        t_ext_sync();
        t_bus();
        t_force();
        t_invalid();
        t_wthru();
        t_generic();
        t_table();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule